// File: doc/BRIEF.md
# DRAM Command/Address Decoder with Parity Alert

This block sits on the device side of a DDR4-style command/address bus. On every rising clock edge it registers the chip-select, the row-open select, the three shared command/row-high pins, the low address pins, the bank-group bit and the bank bits. The registered sample is then decoded into one-hot command strobes: open row, read, write, close one bank, close all banks, refresh, mode-register write, idle and reserved. Each strobe comes with the fields it needs: row, column, bank and mode-register op-code, plus the auto-close and burst-chop qualifiers.

An even-parity checker can be enabled with a configuration input. It is sampled together with the command. When it is on and the chip-select is low, the covered pins together with the parity pin must hold an even number of ones. On a mismatch the command is dropped and the active-low alert output stays low for a fixed, parameterised number of cycles.

The decoder does not model the memory array, timing rules or any data-side function. A command sampled at rising edge k appears on the outputs after rising edge k+1.

Top module: `cmd_addr_decoder`

## Requirements
- R1: At most one command strobe is high in any cycle. The result of a command sampled at rising edge k appears after rising edge k+1 and lasts exactly one cycle.
- R2: When `sel_n_i` is sampled high, no strobe fires and parity is not checked, so no alert results.
- R3: With `sel_n_i` low and `open_row_n_i` low, `open_o` fires. `row_o` is {mux_i[1], mux_i[0], addr_i[13:0]} and `bank_o` is {grp_i, bnk_i}. The pins of `mux_i` are not decoded as a command in this case.
- R4: With `sel_n_i` low and `open_row_n_i` high, `mux_i` selects the command: 3'b000 mode write, 3'b001 refresh, 3'b010 close, 3'b100 write, 3'b101 read, 3'b111 idle. Codes 3'b011 and 3'b110 raise `reserved_o`.
- R5: For close (3'b010), `addr_i[10]`=0 fires `close_o` for bank {grp_i,bnk_i}, and `addr_i[10]`=1 fires `close_all_o`.
- R6: For read and write, `auto_close_o` equals `addr_i[10]`, `chop_o` equals the inverse of `addr_i[12]`, and `col_o` is `addr_i[9:0]`. For every other command both qualifiers are 0.
- R7: For a mode write, `bank_o` gives the target register {grp_i,bnk_i} and `opcode_o` gives `addr_i[13:0]`.
- R8: With parity enabled and `sel_n_i` low, the ones in {open_row_n_i, mux_i, addr_i, grp_i, bnk_i, par_i} must be even. If they are odd, the command is dropped and no strobe fires.
- R9: A parity mismatch drives `alert_n_o` low from the same edge a strobe would have appeared, for ALERT_CYC consecutive cycles. A further mismatch restarts the count.
- R10: With `par_chk_en_i` sampled low, `par_i` has no effect. Commands issue and `alert_n_o` does not fall.
- R11: After reset all strobes and qualifiers are 0 and `alert_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| par_chk_en_i | input | 1 | Parity check enable, sampled with the command |
| sel_n_i | input | 1 | Active-low chip select |
| open_row_n_i | input | 1 | Active-low row-open select |
| mux_i | input | 3 | Shared command/row-high pins (row bits 16..14) |
| addr_i | input | ADDR_W (14) | Address pins 13..0 |
| grp_i | input | GRP_W (1) | Bank group |
| bnk_i | input | BNK_W (2) | Bank within group |
| par_i | input | 1 | Even parity bit for the covered pins |
| open_o | output | 1 | Open-row strobe |
| read_o | output | 1 | Read strobe |
| write_o | output | 1 | Write strobe |
| close_o | output | 1 | Single-bank close strobe |
| close_all_o | output | 1 | All-bank close strobe |
| refresh_o | output | 1 | Refresh strobe |
| mode_o | output | 1 | Mode-register write strobe |
| idle_o | output | 1 | Idle (no-op) strobe |
| reserved_o | output | 1 | Reserved-code strobe |
| auto_close_o | output | 1 | Auto-close qualifier for read/write |
| chop_o | output | 1 | Burst-chop qualifier for read/write |
| row_o | output | ROW_W (16) | Row address, loaded on open |
| col_o | output | COL_W (10) | Column address, loaded on read/write |
| bank_o | output | GRP_W+BNK_W (3) | Bank or mode-register select |
| opcode_o | output | ADDR_W (14) | Mode-register op-code, loaded on mode write |
| alert_n_o | output | 1 | Active-low parity alert |

## Verification
Every result is due one cycle after the sampling edge of its command: strobes, qualifiers, fields and the start of the alert window all show up after edge k+1. The bench holds the expected results of driven commands in a queue that is exactly two entries deep. At each falling edge, before it drives the next command, it compares the oldest entry with the outputs, so each check lands mid-cycle, once both register stages have settled. The alert window is tracked by a countdown in the bench that advances at the same pace. The fields are compared only on the strobes that load them.

// File: rtl/cad_pkg.sv
package cad_pkg;

  typedef enum logic [3:0] {
    CMD_NONE      = 4'd0,
    CMD_OPEN      = 4'd1,
    CMD_READ      = 4'd2,
    CMD_WRITE     = 4'd3,
    CMD_CLOSE     = 4'd4,
    CMD_CLOSE_ALL = 4'd5,
    CMD_REFRESH   = 4'd6,
    CMD_MODE      = 4'd7,
    CMD_IDLE      = 4'd8,
    CMD_RSVD      = 4'd9
  } cmd_e;

  // strobe vector index = enum value - 1
  localparam int NUM_STB     = 9;
  localparam int S_OPEN      = 0;
  localparam int S_READ      = 1;
  localparam int S_WRITE     = 2;
  localparam int S_CLOSE     = 3;
  localparam int S_CLOSE_ALL = 4;
  localparam int S_REFRESH   = 5;
  localparam int S_MODE      = 6;
  localparam int S_IDLE      = 7;
  localparam int S_RSVD      = 8;

  // command codes on the shared pins {bit2,bit1,bit0}
  localparam logic [2:0] OP_MODE    = 3'b000;
  localparam logic [2:0] OP_REFRESH = 3'b001;
  localparam logic [2:0] OP_CLOSE   = 3'b010;
  localparam logic [2:0] OP_WRITE   = 3'b100;
  localparam logic [2:0] OP_READ    = 3'b101;
  localparam logic [2:0] OP_IDLE    = 3'b111;

  // qualifier bit positions inside the address pins
  localparam int AUTO_BIT = 10;
  localparam int CHOP_BIT = 12;

endpackage

// File: rtl/cad_capture.sv
module cad_capture #(
  parameter int ADDR_W = 14,
  parameter int GRP_W  = 1,
  parameter int BNK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              sel_n_i,
  input  logic              open_n_i,
  input  logic [2:0]        mux_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [BNK_W-1:0]  bnk_i,
  input  logic              par_i,
  output logic              en_q,
  output logic              sel_n_q,
  output logic              open_n_q,
  output logic [2:0]        mux_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [GRP_W-1:0]  grp_q,
  output logic [BNK_W-1:0]  bnk_q,
  output logic              par_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sel_n_q  <= 1'b1;
      open_n_q <= 1'b1;
      mux_q    <= '1;
      addr_q   <= '0;
      grp_q    <= '0;
      bnk_q    <= '0;
      par_q    <= 1'b0;
    end else begin
      en_q     <= en_i;
      sel_n_q  <= sel_n_i;
      open_n_q <= open_n_i;
      mux_q    <= mux_i;
      addr_q   <= addr_i;
      grp_q    <= grp_i;
      bnk_q    <= bnk_i;
      par_q    <= par_i;
    end
  end

endmodule

// File: rtl/cad_decode.sv
module cad_decode
  import cad_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              sel_n_i,
  input  logic              open_n_i,
  input  logic [2:0]        mux_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o,
  output logic              auto_o,
  output logic              chop_o
);

  logic rw;

  always_comb begin
    cmd_o = CMD_NONE;
    if (!sel_n_i) begin
      if (!open_n_i) begin
        cmd_o = CMD_OPEN;
      end else begin
        case (mux_i)
          OP_MODE:    cmd_o = CMD_MODE;
          OP_REFRESH: cmd_o = CMD_REFRESH;
          OP_CLOSE:   cmd_o = addr_i[AUTO_BIT] ? CMD_CLOSE_ALL : CMD_CLOSE;
          OP_WRITE:   cmd_o = CMD_WRITE;
          OP_READ:    cmd_o = CMD_READ;
          OP_IDLE:    cmd_o = CMD_IDLE;
          default:    cmd_o = CMD_RSVD;
        endcase
      end
    end
  end

  assign rw     = (cmd_o == CMD_READ) || (cmd_o == CMD_WRITE);
  assign auto_o = rw & addr_i[AUTO_BIT];
  assign chop_o = rw & ~addr_i[CHOP_BIT];

endmodule

// File: rtl/cad_parity.sv
module cad_parity #(
  parameter int COVER_W = 20
) (
  input  logic               en_i,
  input  logic               sel_n_i,
  input  logic [COVER_W-1:0] cover_i,
  input  logic               par_i,
  output logic               err_o
);

  logic odd;

  assign odd   = ^{cover_i, par_i};
  assign err_o = en_i & ~sel_n_i & odd;

endmodule

// File: rtl/cad_alert.sv
module cad_alert #(
  parameter int ALERT_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  output logic alert_n_o
);

  localparam int CNT_W = $clog2(ALERT_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = err_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (err_i)            cnt_d = CNT_W'(ALERT_CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign alert_n_o = (cnt_q == '0);

endmodule

// File: rtl/cmd_addr_decoder.sv
module cmd_addr_decoder
  import cad_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int GRP_W     = 1,
  parameter int BNK_W     = 2,
  parameter int ROW_W     = 16,
  parameter int COL_W     = 10,
  parameter int ALERT_CYC = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   par_chk_en_i,
  input  logic                   sel_n_i,
  input  logic                   open_row_n_i,
  input  logic [2:0]             mux_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [GRP_W-1:0]       grp_i,
  input  logic [BNK_W-1:0]       bnk_i,
  input  logic                   par_i,
  output logic                   open_o,
  output logic                   read_o,
  output logic                   write_o,
  output logic                   close_o,
  output logic                   close_all_o,
  output logic                   refresh_o,
  output logic                   mode_o,
  output logic                   idle_o,
  output logic                   reserved_o,
  output logic                   auto_close_o,
  output logic                   chop_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic [GRP_W+BNK_W-1:0] bank_o,
  output logic [ADDR_W-1:0]      opcode_o,
  output logic                   alert_n_o
);

  localparam int BANK_W  = GRP_W + BNK_W;
  localparam int FULL_W  = 3 + ADDR_W;
  localparam int COVER_W = 1 + FULL_W + BANK_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // stage 1: pin capture
  logic              cap_en_q, cap_sel_q, cap_open_q, cap_par_q;
  logic [2:0]        cap_mux_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [GRP_W-1:0]  cap_grp_q;
  logic [BNK_W-1:0]  cap_bnk_q;

  cad_capture #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .BNK_W(BNK_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (par_chk_en_i),
    .sel_n_i  (sel_n_i),
    .open_n_i (open_row_n_i),
    .mux_i    (mux_i),
    .addr_i   (addr_i),
    .grp_i    (grp_i),
    .bnk_i    (bnk_i),
    .par_i    (par_i),
    .en_q     (cap_en_q),
    .sel_n_q  (cap_sel_q),
    .open_n_q (cap_open_q),
    .mux_q    (cap_mux_q),
    .addr_q   (cap_addr_q),
    .grp_q    (cap_grp_q),
    .bnk_q    (cap_bnk_q),
    .par_q    (cap_par_q)
  );

  // decode and parity
  cmd_e dec_cmd;
  logic dec_auto, dec_chop, par_err;

  cad_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_n_i  (cap_sel_q),
    .open_n_i (cap_open_q),
    .mux_i    (cap_mux_q),
    .addr_i   (cap_addr_q),
    .cmd_o    (dec_cmd),
    .auto_o   (dec_auto),
    .chop_o   (dec_chop)
  );

  cad_parity #(.COVER_W(COVER_W)) u_par (
    .en_i    (cap_en_q),
    .sel_n_i (cap_sel_q),
    .cover_i ({cap_open_q, cap_mux_q, cap_addr_q, cap_grp_q, cap_bnk_q}),
    .par_i   (cap_par_q),
    .err_o   (par_err)
  );

  cad_alert #(.ALERT_CYC(ALERT_CYC)) u_alert (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .err_i     (par_err),
    .alert_n_o (alert_n_o)
  );

  // stage 2: next state
  cmd_e                iss_cmd;
  logic [NUM_STB-1:0]  stb_d, stb_q;
  logic                auto_d, chop_d, auto_q, chop_q;
  logic                ld_row, ld_col, ld_bank, ld_op;
  logic [FULL_W-1:0]   full_addr;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q;
  logic [BANK_W-1:0]   bank_q;
  logic [ADDR_W-1:0]   op_q;

  assign iss_cmd   = par_err ? CMD_NONE : dec_cmd;
  assign full_addr = {cap_mux_q, cap_addr_q};

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    assign stb_d[g] = (iss_cmd == cmd_e'(g + 1));
  end

  always_comb begin
    auto_d  = dec_auto & ~par_err;
    chop_d  = dec_chop & ~par_err;
    ld_row  = stb_d[S_OPEN];
    ld_col  = stb_d[S_READ] | stb_d[S_WRITE];
    ld_bank = stb_d[S_OPEN] | stb_d[S_READ] | stb_d[S_WRITE] |
              stb_d[S_CLOSE] | stb_d[S_MODE];
    ld_op   = stb_d[S_MODE];
  end

  // stage 2: registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stb_q  <= '0;
      auto_q <= 1'b0;
      chop_q <= 1'b0;
    end else begin
      stb_q  <= stb_d;
      auto_q <= auto_d;
      chop_q <= chop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) row_q <= '0;
    else if (ld_row) row_q <= full_addr[ROW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) col_q <= '0;
    else if (ld_col) col_q <= cap_addr_q[COL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  bank_q <= '0;
    else if (ld_bank) bank_q <= {cap_grp_q, cap_bnk_q};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) op_q <= '0;
    else if (ld_op)  op_q <= cap_addr_q;
  end

  assign open_o       = stb_q[S_OPEN];
  assign read_o       = stb_q[S_READ];
  assign write_o      = stb_q[S_WRITE];
  assign close_o      = stb_q[S_CLOSE];
  assign close_all_o  = stb_q[S_CLOSE_ALL];
  assign refresh_o    = stb_q[S_REFRESH];
  assign mode_o       = stb_q[S_MODE];
  assign idle_o       = stb_q[S_IDLE];
  assign reserved_o   = stb_q[S_RSVD];
  assign auto_close_o = auto_q;
  assign chop_o       = chop_q;
  assign row_o        = row_q;
  assign col_o        = col_q;
  assign bank_o       = bank_q;
  assign opcode_o     = op_q;

endmodule

// File: rtl/cad_checker.sv
module cad_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cap_sel_q,
  input logic       cap_open_q,
  input logic       par_err,
  input logic [8:0] stb,
  input logic       open_o,
  input logic       read_o,
  input logic       write_o,
  input logic       auto_close_o,
  input logic       chop_o,
  input logic       alert_n_o
);

  assert_onehot_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  assert_deselect_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_sel_q |=> (stb == 9'd0));

  assert_open_issued_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_sel_q && !cap_open_q && !par_err) |=> open_o);

  assert_qualifier_rw_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_close_o || chop_o) |-> (read_o || write_o));

  assert_bad_parity_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> (stb == 9'd0));

  assert_alert_follows_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !alert_n_o);

  assert_alert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n_o) |-> $past(par_err));

endmodule

bind cmd_addr_decoder cad_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cap_sel_q    (cap_sel_q),
  .cap_open_q   (cap_open_q),
  .par_err      (par_err),
  .stb          (stb_q),
  .open_o       (open_o),
  .read_o       (read_o),
  .write_o      (write_o),
  .auto_close_o (auto_close_o),
  .chop_o       (chop_o),
  .alert_n_o    (alert_n_o)
);

// File: tb/tb_cmd_addr_decoder.sv
`timescale 1ns/1ps
module tb_cmd_addr_decoder;

  localparam int ALERT_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        par_chk_en_i, sel_n_i, open_row_n_i, par_i;
  logic [2:0]  mux_i;
  logic [13:0] addr_i;
  logic [0:0]  grp_i;
  logic [1:0]  bnk_i;
  logic        open_o, read_o, write_o, close_o, close_all_o, refresh_o;
  logic        mode_o, idle_o, reserved_o, auto_close_o, chop_o, alert_n_o;
  logic [15:0] row_o;
  logic [9:0]  col_o;
  logic [2:0]  bank_o;
  logic [13:0] opcode_o;

  always #2 clk = ~clk;

  cmd_addr_decoder #(.ALERT_CYC(ALERT_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .par_chk_en_i(par_chk_en_i), .sel_n_i(sel_n_i),
    .open_row_n_i(open_row_n_i), .mux_i(mux_i), .addr_i(addr_i), .grp_i(grp_i),
    .bnk_i(bnk_i), .par_i(par_i), .open_o(open_o), .read_o(read_o),
    .write_o(write_o), .close_o(close_o), .close_all_o(close_all_o),
    .refresh_o(refresh_o), .mode_o(mode_o), .idle_o(idle_o),
    .reserved_o(reserved_o), .auto_close_o(auto_close_o), .chop_o(chop_o),
    .row_o(row_o), .col_o(col_o), .bank_o(bank_o), .opcode_o(opcode_o),
    .alert_n_o(alert_n_o)
  );

  typedef struct {
    bit [8:0]  stb;   // 0 open,1 read,2 write,3 close,4 close-all,5 refresh,6 mode,7 idle,8 reserved
    bit        ac;
    bit        ch;
    bit [15:0] row;
    bit [9:0]  col;
    bit [2:0]  bank;
    bit [13:0] op;
    bit        err;
    bit        sel;
    bit        en;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   acnt   = 0;

  function automatic exp_t model(bit en, bit sel, bit opn, bit [2:0] m,
                                 bit [13:0] a, bit g, bit [1:0] b, bit p);
    exp_t e;
    int   ones;
    e = '{default: 0};
    e.sel = sel;
    e.en  = en;
    ones  = $countones({opn, m, a, g, b, p});
    e.err = en && !sel && (ones % 2 == 1);
    if (!sel && !e.err) begin
      if (!opn) e.stb[0] = 1'b1;
      else if (m == 3'd0) e.stb[6] = 1'b1;
      else if (m == 3'd1) e.stb[5] = 1'b1;
      else if (m == 3'd2) begin
        if (a[10]) e.stb[4] = 1'b1; else e.stb[3] = 1'b1;
      end
      else if (m == 3'd4) e.stb[2] = 1'b1;
      else if (m == 3'd5) e.stb[1] = 1'b1;
      else if (m == 3'd7) e.stb[7] = 1'b1;
      else e.stb[8] = 1'b1;
    end
    e.ac   = (e.stb[1] || e.stb[2]) && a[10];
    e.ch   = (e.stb[1] || e.stb[2]) && !a[12];
    e.row  = {m[1:0], a};
    e.col  = a[9:0];
    e.bank = {g, b};
    e.op   = a;
    return e;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit [8:0] got_stb();
    return {reserved_o, idle_o, mode_o, refresh_o, close_all_o, close_o,
            write_o, read_o, open_o};
  endfunction

  task automatic check_front();
    exp_t  e;
    string tag;
    if (q.size() < 2) return;
    e = q.pop_front();
    if (e.sel)                           tag = "R2";
    else if (e.err)                      tag = "R8";
    else if (e.stb[0])                   tag = "R3";
    else if (e.stb[3] || e.stb[4])       tag = "R5";
    else if (e.stb[1] || e.stb[2])       tag = "R6";
    else if (e.stb[6])                   tag = "R7";
    else if (!e.en)                      tag = "R10";
    else                                 tag = "R4";
    chk(tag, "strobes(R1)", got_stb(), e.stb);
    chk("R6", "auto_close", auto_close_o, e.ac);
    chk("R6", "chop", chop_o, e.ch);
    if (e.stb[0]) chk("R3", "row", row_o, e.row);
    if (e.stb[1] || e.stb[2]) chk("R6", "col", col_o, e.col);
    if (e.stb[0] || e.stb[1] || e.stb[2] || e.stb[3] || e.stb[6])
      chk(tag, "bank", bank_o, e.bank);
    if (e.stb[6]) chk("R7", "opcode", opcode_o, e.op);
    if (e.err) acnt = ALERT_CYC;
    else if (acnt > 0) acnt--;
    chk(e.en ? "R9" : "R10", "alert_n", alert_n_o, (acnt == 0));
  endtask

  task automatic step(bit en, bit sel, bit opn, bit [2:0] m, bit [13:0] a,
                      bit g, bit [1:0] b, bit bad);
    bit p;
    @(negedge clk);
    check_front();
    p = (^{opn, m, a, g, b}) ^ bad;
    par_chk_en_i = en; sel_n_i = sel; open_row_n_i = opn; mux_i = m;
    addr_i = a; grp_i = g; bnk_i = b; par_i = p;
    q.push_back(model(en, sel, opn, m, a, g, b, p));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    par_chk_en_i = 1'b1; sel_n_i = 1'b1; open_row_n_i = 1'b1; mux_i = 3'b111;
    addr_i = '0; grp_i = '0; bnk_i = '0; par_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11", "strobes", got_stb(), 9'd0);
    chk("R11", "qualifiers", {auto_close_o, chop_o}, 2'b00);
    chk("R11", "alert_n", alert_n_o, 1'b1);

    // directed
    step(1, 0, 0, 3'b110, 14'h2A5C, 1, 2'b10, 0);   // R3 open, row uses mux bits
    step(1, 0, 1, 3'b101, 14'h0523, 0, 2'b01, 0);   // R6 read, a10=1 a12=0
    step(1, 0, 1, 3'b100, 14'h1011, 1, 2'b11, 0);   // R6 write, a10=0 a12=1
    step(1, 0, 1, 3'b010, 14'h0000, 1, 2'b01, 0);   // R5 close one
    step(1, 0, 1, 3'b010, 14'h0400, 0, 2'b00, 0);   // R5 close all
    step(1, 0, 1, 3'b001, 14'h3FFF, 0, 2'b00, 0);   // R4 refresh
    step(1, 0, 1, 3'b000, 14'h1ABC, 1, 2'b10, 0);   // R7 mode write
    step(1, 0, 1, 3'b111, 14'h0000, 0, 2'b00, 0);   // R4 idle
    step(1, 0, 1, 3'b011, 14'h0001, 0, 2'b00, 0);   // R4 reserved
    step(1, 0, 1, 3'b110, 14'h0002, 0, 2'b00, 0);   // R4 reserved
    step(1, 1, 0, 3'b000, 14'h1234, 0, 2'b00, 1);   // R2 deselect, bad parity
    step(1, 0, 1, 3'b101, 14'h0400, 0, 2'b00, 1);   // R8 bad parity read
    step(1, 0, 1, 3'b111, 14'h0000, 0, 2'b00, 0);
    step(1, 0, 1, 3'b111, 14'h0000, 0, 2'b00, 0);
    step(1, 0, 0, 3'b000, 14'h0777, 1, 2'b00, 1);   // R9 restart during window
    for (int i = 0; i < 8; i++) step(1, 0, 1, 3'b111, 14'h0, 0, 2'b00, 0);
    step(0, 0, 1, 3'b100, 14'h1400, 1, 2'b01, 1);   // R10 parity off
    step(0, 0, 0, 3'b101, 14'h0F0F, 0, 2'b11, 1);   // R10 parity off

    // pseudo-random
    for (int i = 0; i < 2000; i++) begin
      step(($urandom_range(0, 9) != 0), ($urandom_range(0, 4) == 0),
           ($urandom_range(0, 5) != 0), 3'($urandom_range(0, 7)),
           14'($urandom_range(0, 16383)), 1'($urandom_range(0, 1)),
           2'($urandom_range(0, 3)), ($urandom_range(0, 11) == 0));
    end
    step(1, 1, 1, 3'b111, 14'h0, 0, 2'b00, 0);
    step(1, 1, 1, 3'b111, 14'h0, 0, 2'b00, 0);
    @(negedge clk);
    check_front();
    summary();
    $finish;
  end

endmodule